// File: doc/BRIEF.md
# Three-Port Bridge Claim Decoder

This block sits behind the address decoders of a bridge with one upstream (primary) port and two downstream (secondary) ports. When a new bus cycle starts on any port, it gets the originating port, the port that owns the address, whether the cycle may be posted, the fill status of the posting buffers and whether some other agent already drove device select. From these it decides whether the bridge claims the cycle. A cycle aimed back at its own port, or at no port, is left alone. A claimed cycle either completes at once, is refused with a retry, or is turned into a delayed transaction.

A cycle that cannot be posted is held in a single delayed entry (command, address, originating port) and forwarded to the destination port. The destination side reports completion, and the initiator's identical retry then ends normally and frees the entry. Every decision is registered, so device select and the termination code appear one clock after the address phase, on the originating port only.

Port codes: 0 primary, 1 secondary 1, 2 secondary 2, 3 no destination. Termination codes: 2'b00 not claimed, 2'b01 normal, 2'b10 retry.

Top module: `tpb_claim_decoder`

## Requirements
- R1: A cycle whose destination equals its origin, or one that another agent already selected (`ext_sel_i`=1), is not claimed: no device select, termination 2'b00, no forward.
- R2: A postable cycle from the primary port to secondary 1 or 2, with room in the buffer toward that port, ends normally (2'b01) with device select on the primary port (bit 0) and a forward request; this also holds while a delayed entry is pending.
- R3: A claimed non-postable cycle with no pending entry is retried (2'b10), captured as the delayed entry and forwarded with `fwd_port_o` set to the destination code.
- R4: A cycle with destination code 3 is not claimed, whatever its origin or postability.
- R5: A cycle from a secondary port whose destination is the same secondary port is not claimed.
- R6: A cycle from secondary 1 (bit 1) or secondary 2 (bit 2) aimed at the primary port or the other secondary port is claimed on the originating port's device-select bit.
- R7: After `cpl_done_i`, the identical repeat of the pending cycle ends normally without a new forward, and the entry is freed so the next non-postable cycle is captured again.
- R8: A postable claimed cycle whose destination buffer is full (`buf_full_i` bit indexed by destination code) is retried without a forward; fullness of other ports has no effect.
- R9: While an entry is pending, a claimed non-postable cycle differing in command, address or origin, or a matching repeat before completion, is retried without a forward.
- R10: Device select is at most one-hot, appears exactly one clock after the address phase on the origin's bit, and lasts one clock.
- R11: After reset, device select, the response strobe and the forward request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid_i | input | 1 | Address phase of a new cycle |
| src_port_i | input | 2 | Originating port code |
| dst_port_i | input | 2 | Decoded destination port code |
| postable_i | input | 1 | Cycle may be posted |
| buf_full_i | input | 3 | Posting buffer full, one bit per destination port |
| ext_sel_i | input | 1 | Another agent asserted device select |
| cmd_i | input | CMD_W | Bus command |
| addr_i | input | ADDR_W | Cycle address |
| cpl_done_i | input | 1 | Destination side completed the pending delayed cycle |
| devsel_o | output | 3 | Device select, one bit per port |
| resp_valid_o | output | 1 | Decision strobe, one clock after the address phase |
| term_o | output | 2 | Termination code |
| fwd_valid_o | output | 1 | Forward request |
| fwd_port_o | output | 2 | Port the cycle is forwarded to |

## Verification
The assertions check on every cycle that device select is at most one-hot, sits on the origin's bit one clock after an address phase, never follows an unclaimed or self-targeted cycle, and that a postable cycle with buffer room ends normally. Whether a repeat is matched on all three fields, that completion frees the entry, and that a full buffer on one port leaves the others unaffected depend on sequences of cycles, which only the bench's scenarios can show.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
  typedef enum logic [1:0] {
    PORT_PRI  = 2'd0,
    PORT_SEC1 = 2'd1,
    PORT_SEC2 = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  typedef enum logic [1:0] {
    TERM_NOCLAIM = 2'b00,
    TERM_NORMAL  = 2'b01,
    TERM_RETRY   = 2'b10
  } term_e;

  localparam int unsigned NPORT = 3;
endpackage

// File: rtl/tpb_route_decode.sv
module tpb_route_decode
  import tpb_pkg::*;
#(
  parameter int unsigned NP = NPORT
) (
  input  logic [1:0]    src_port_i,
  input  logic [1:0]    dst_port_i,
  input  logic          ext_sel_i,
  input  logic [NP-1:0] buf_full_i,
  output logic          claim_o,
  output logic          dst_full_o,
  output logic [NP-1:0] sel_vec_o
);
  logic [NP-1:0] dst_hot;

  generate
    for (genvar p = 0; p < NP; p++) begin : g_port
      assign sel_vec_o[p] = (src_port_i == p[1:0]);
      assign dst_hot[p]   = (dst_port_i == p[1:0]);
    end
  endgenerate

  always_comb begin
    claim_o    = (dst_port_i != PORT_NONE) && (dst_port_i != src_port_i) && !ext_sel_i;
    dst_full_o = |(dst_hot & buf_full_i);
  end
endmodule

// File: rtl/tpb_delayed_entry.sv
module tpb_delayed_entry #(
  parameter int unsigned CMD_W  = 4,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              release_i,
  input  logic              cpl_done_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        src_i,
  output logic              pend_o,
  output logic              done_o,
  output logic              match_o
);
  logic              pend_q, pend_d;
  logic              done_q, done_d;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        src_q;
  logic              load_en;

  always_comb begin
    load_en = capture_i && !pend_q;
    pend_d  = pend_q;
    done_d  = done_q;
    if (load_en) begin
      pend_d = 1'b1;
      done_d = 1'b0;
    end else if (release_i) begin
      pend_d = 1'b0;
      done_d = 1'b0;
    end else if (pend_q && cpl_done_i) begin
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      src_q  <= '0;
    end else if (load_en) begin
      cmd_q  <= cmd_i;
      addr_q <= addr_i;
      src_q  <= src_i;
    end
  end

  assign pend_o  = pend_q;
  assign done_o  = done_q;
  assign match_o = pend_q && (cmd_q == cmd_i) && (addr_q == addr_i) && (src_q == src_i);
endmodule

// File: rtl/tpb_claim_decoder.sv
module tpb_claim_decoder
  import tpb_pkg::*;
#(
  parameter int unsigned CMD_W  = 4,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid_i,
  input  logic [1:0]        src_port_i,
  input  logic [1:0]        dst_port_i,
  input  logic              postable_i,
  input  logic [2:0]        buf_full_i,
  input  logic              ext_sel_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpl_done_i,
  output logic [2:0]        devsel_o,
  output logic              resp_valid_o,
  output logic [1:0]        term_o,
  output logic              fwd_valid_o,
  output logic [1:0]        fwd_port_o
);
  logic          claim, dst_full;
  logic [NPORT-1:0] sel_vec;
  logic          pend, done, match;
  logic          capture, release_e;

  logic [2:0] devsel_d, devsel_q;
  logic       resp_d, resp_q;
  logic [1:0] term_d, term_q;
  logic       fwd_d, fwd_q;
  logic [1:0] fport_d, fport_q;

  tpb_route_decode #(.NP(NPORT)) u_route (
    .src_port_i (src_port_i),
    .dst_port_i (dst_port_i),
    .ext_sel_i  (ext_sel_i),
    .buf_full_i (buf_full_i),
    .claim_o    (claim),
    .dst_full_o (dst_full),
    .sel_vec_o  (sel_vec)
  );

  tpb_delayed_entry #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_entry (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_i  (capture),
    .release_i  (release_e),
    .cpl_done_i (cpl_done_i),
    .cmd_i      (cmd_i),
    .addr_i     (addr_i),
    .src_i      (src_port_i),
    .pend_o     (pend),
    .done_o     (done),
    .match_o    (match)
  );

  always_comb begin
    devsel_d  = '0;
    resp_d    = cyc_valid_i;
    term_d    = TERM_NOCLAIM;
    fwd_d     = 1'b0;
    fport_d   = fport_q;
    capture   = 1'b0;
    release_e = 1'b0;
    if (cyc_valid_i && claim) begin
      devsel_d = sel_vec;
      if (postable_i) begin
        if (dst_full) begin
          term_d = TERM_RETRY;
        end else begin
          term_d  = TERM_NORMAL;
          fwd_d   = 1'b1;
          fport_d = dst_port_i;
        end
      end else if (!pend) begin
        term_d  = TERM_RETRY;
        capture = 1'b1;
        fwd_d   = 1'b1;
        fport_d = dst_port_i;
      end else if (match && done) begin
        term_d    = TERM_NORMAL;
        release_e = 1'b1;
      end else begin
        term_d = TERM_RETRY;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devsel_q <= '0;
      resp_q   <= 1'b0;
      term_q   <= TERM_NOCLAIM;
      fwd_q    <= 1'b0;
      fport_q  <= PORT_NONE;
    end else begin
      devsel_q <= devsel_d;
      resp_q   <= resp_d;
      term_q   <= term_d;
      fwd_q    <= fwd_d;
      fport_q  <= fport_d;
    end
  end

  assign devsel_o     = devsel_q;
  assign resp_valid_o = resp_q;
  assign term_o       = term_q;
  assign fwd_valid_o  = fwd_q;
  assign fwd_port_o   = fport_q;
endmodule

// File: rtl/tpb_claim_checker.sv
module tpb_claim_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_valid_i,
  input logic [1:0] src_port_i,
  input logic [1:0] dst_port_i,
  input logic       postable_i,
  input logic [2:0] buf_full_i,
  input logic       ext_sel_i,
  input logic [2:0] devsel_o,
  input logic       resp_valid_o,
  input logic [1:0] term_o,
  input logic       fwd_valid_o
);
  assert_devsel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(devsel_o));

  assert_devsel_after_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid_i |=> (devsel_o == 3'b000));

  assert_devsel_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid_i && src_port_i != 2'd3) |=> (devsel_o == 3'b000 || devsel_o[$past(src_port_i)]));

  assert_self_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid_i && dst_port_i == src_port_i) |=> (devsel_o == 3'b000 && term_o == 2'b00 && !fwd_valid_o));

  assert_no_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid_i && dst_port_i == 2'd3) |=> (devsel_o == 3'b000 && term_o == 2'b00));

  assert_ext_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid_i && ext_sel_i) |=> (devsel_o == 3'b000 && !fwd_valid_o));

  assert_posted_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid_i && postable_i && !ext_sel_i && dst_port_i != 2'd3 && dst_port_i != src_port_i
     && !buf_full_i[dst_port_i]) |=> (term_o == 2'b01 && fwd_valid_o));

  assert_full_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid_i && postable_i && !ext_sel_i && dst_port_i != 2'd3 && dst_port_i != src_port_i
     && buf_full_i[dst_port_i]) |=> (term_o == 2'b10 && !fwd_valid_o));

  assert_strobe_claim_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (devsel_o != 3'b000) |-> (resp_valid_o && term_o != 2'b00));
endmodule

bind tpb_claim_decoder tpb_claim_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cyc_valid_i  (cyc_valid_i),
  .src_port_i   (src_port_i),
  .dst_port_i   (dst_port_i),
  .postable_i   (postable_i),
  .buf_full_i   (buf_full_i),
  .ext_sel_i    (ext_sel_i),
  .devsel_o     (devsel_o),
  .resp_valid_o (resp_valid_o),
  .term_o       (term_o),
  .fwd_valid_o  (fwd_valid_o)
);

// File: tb/tpb_claim_decoder_test.sv
module tpb_claim_decoder_test;
  localparam int CMD_W  = 4;
  localparam int ADDR_W = 32;
  localparam int NVEC   = 16;

  logic              clk;
  logic              rst_n;
  logic              cyc_valid_i;
  logic [1:0]        src_port_i, dst_port_i;
  logic              postable_i;
  logic [2:0]        buf_full_i;
  logic              ext_sel_i;
  logic [CMD_W-1:0]  cmd_i;
  logic [ADDR_W-1:0] addr_i;
  logic              cpl_done_i;
  logic [2:0]        devsel_o;
  logic              resp_valid_o;
  logic [1:0]        term_o;
  logic              fwd_valid_o;
  logic [1:0]        fwd_port_o;

  int errors = 0;
  int checks = 0;

  tpb_claim_decoder #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .cyc_valid_i(cyc_valid_i),
    .src_port_i(src_port_i), .dst_port_i(dst_port_i), .postable_i(postable_i),
    .buf_full_i(buf_full_i), .ext_sel_i(ext_sel_i), .cmd_i(cmd_i), .addr_i(addr_i),
    .cpl_done_i(cpl_done_i), .devsel_o(devsel_o), .resp_valid_o(resp_valid_o),
    .term_o(term_o), .fwd_valid_o(fwd_valid_o), .fwd_port_o(fwd_port_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {src, dst, postable, full[2:0], ext, exp_devsel[2:0], exp_term, exp_fwd}
  localparam logic [14:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 1'b1, 3'b000, 1'b0, 3'b000, 2'b00, 1'b0},  // R1
    {2'd0, 2'd1, 1'b1, 3'b000, 1'b0, 3'b001, 2'b01, 1'b1},  // R2
    {2'd0, 2'd2, 1'b1, 3'b000, 1'b0, 3'b001, 2'b01, 1'b1},  // R2
    {2'd0, 2'd3, 1'b1, 3'b000, 1'b0, 3'b000, 2'b00, 1'b0},  // R4
    {2'd0, 2'd3, 1'b0, 3'b000, 1'b0, 3'b000, 2'b00, 1'b0},  // R4
    {2'd1, 2'd1, 1'b1, 3'b000, 1'b0, 3'b000, 2'b00, 1'b0},  // R5
    {2'd2, 2'd2, 1'b0, 3'b000, 1'b0, 3'b000, 2'b00, 1'b0},  // R5
    {2'd1, 2'd0, 1'b1, 3'b000, 1'b0, 3'b010, 2'b01, 1'b1},  // R6
    {2'd1, 2'd2, 1'b1, 3'b000, 1'b0, 3'b010, 2'b01, 1'b1},  // R6
    {2'd2, 2'd1, 1'b1, 3'b000, 1'b0, 3'b100, 2'b01, 1'b1},  // R6
    {2'd2, 2'd0, 1'b1, 3'b000, 1'b0, 3'b100, 2'b01, 1'b1},  // R6
    {2'd0, 2'd1, 1'b1, 3'b010, 1'b0, 3'b001, 2'b10, 1'b0},  // R8
    {2'd0, 2'd1, 1'b1, 3'b100, 1'b0, 3'b001, 2'b01, 1'b1},  // R8 other port full
    {2'd2, 2'd0, 1'b1, 3'b001, 1'b0, 3'b100, 2'b10, 1'b0},  // R8
    {2'd0, 2'd1, 1'b1, 3'b000, 1'b1, 3'b000, 2'b00, 1'b0},  // R1 external select
    {2'd1, 2'd3, 1'b1, 3'b000, 1'b0, 3'b000, 2'b00, 1'b0}   // R4
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one address phase, sample the registered response just after the edge
  task automatic issue(input logic [1:0] s, input logic [1:0] d, input logic p,
                       input logic [2:0] f, input logic e,
                       input logic [3:0] c, input logic [31:0] a);
    @(negedge clk);
    cyc_valid_i = 1'b1; src_port_i = s; dst_port_i = d; postable_i = p;
    buf_full_i = f; ext_sel_i = e; cmd_i = c; addr_i = a;
    @(posedge clk);
    #1;
    @(negedge clk);
    cyc_valid_i = 1'b0;
  endtask

  task automatic expect_resp(input string req, input logic [2:0] dv, input logic [1:0] tm,
                             input logic fw);
    check(req, {5'd0, devsel_o}, {5'd0, dv});
    check(req, {6'd0, term_o}, {6'd0, tm});
    check(req, {7'd0, fwd_valid_o}, {7'd0, fw});
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc_valid_i = 1'b0; src_port_i = '0; dst_port_i = '0;
    postable_i = 1'b0; buf_full_i = '0; ext_sel_i = 1'b0; cmd_i = '0;
    addr_i = '0; cpl_done_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 devsel", {5'd0, devsel_o}, 8'd0);
    check("R11 resp", {7'd0, resp_valid_o}, 8'd0);
    check("R11 fwd", {7'd0, fwd_valid_o}, 8'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][14:13], VEC[i][12:11], VEC[i][10], VEC[i][9:7], VEC[i][6],
            4'h7, 32'h1000 + i);
      // at the negedge after the address phase: response is visible
      expect_resp($sformatf("vector %0d (R1 R2 R4 R5 R6 R8)", i),
                  VEC[i][5:3], VEC[i][2:1], VEC[i][0]);
      check("R10 strobe", {7'd0, resp_valid_o}, 8'd1);
      @(negedge clk);
      check("R10 one clock", {5'd0, devsel_o}, 8'd0);
    end

    // R3: non-postable primary -> secondary 2 captured and forwarded
    issue(2'd0, 2'd2, 1'b0, 3'b000, 1'b0, 4'h6, 32'hA000_0040);
    expect_resp("R3 capture", 3'b001, 2'b10, 1'b1);
    check("R3 fwd port", {6'd0, fwd_port_o}, 8'd2);

    // R9: matching repeat before completion
    issue(2'd0, 2'd2, 1'b0, 3'b000, 1'b0, 4'h6, 32'hA000_0040);
    expect_resp("R9 early repeat", 3'b001, 2'b10, 1'b0);
    // R9: different address
    issue(2'd0, 2'd2, 1'b0, 3'b000, 1'b0, 4'h6, 32'hA000_0044);
    expect_resp("R9 addr differs", 3'b001, 2'b10, 1'b0);
    // R9: different command
    issue(2'd0, 2'd2, 1'b0, 3'b000, 1'b0, 4'h2, 32'hA000_0040);
    expect_resp("R9 cmd differs", 3'b001, 2'b10, 1'b0);

    // completion arrives
    @(negedge clk) cpl_done_i = 1'b1;
    @(negedge clk) cpl_done_i = 1'b0;

    // R9: same cmd/addr from another origin still retried
    issue(2'd1, 2'd2, 1'b0, 3'b000, 1'b0, 4'h6, 32'hA000_0040);
    expect_resp("R9 origin differs", 3'b010, 2'b10, 1'b0);
    // R2: posted cycle passes the pending entry
    issue(2'd0, 2'd1, 1'b1, 3'b000, 1'b0, 4'h7, 32'hB000_0000);
    expect_resp("R2 posted while pending", 3'b001, 2'b01, 1'b1);
    // R7: identical repeat after completion ends normally
    issue(2'd0, 2'd2, 1'b0, 3'b000, 1'b0, 4'h6, 32'hA000_0040);
    expect_resp("R7 repeat done", 3'b001, 2'b01, 1'b0);
    // R7: entry freed, next delayed cycle captured and forwarded
    issue(2'd2, 2'd0, 1'b0, 3'b000, 1'b0, 4'h3, 32'hC000_0010);
    expect_resp("R7 entry freed", 3'b100, 2'b10, 1'b1);
    check("R7 fwd port", {6'd0, fwd_port_o}, 8'd0);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule